// File: doc/BRIEF.md
# Two-Level Five-Source Interrupt Controller

This block gathers five interrupt sources for a small 8-bit CPU: an external line 0, a timer 0 overflow, an external line 1, a timer 1 overflow and a serial port that requests service when either its receive-done or transmit-done flag is set. Each source can be masked on its own, and one global enable gates all of them. Each source is ranked as either low or high priority. When an eligible source wins arbitration, the block raises a request to the CPU together with a fixed 16-bit vector address. It then waits for the CPU to acknowledge.

The block records which priority levels are currently being serviced. A high-priority source may interrupt a running low-priority handler. A source at the same level or a lower level waits until the CPU signals a return from interrupt. Each return releases the highest level that is in service. Reset is the non-maskable event above everything else: it returns every register to its default, and all defaults are zero.

The CPU stack push, the timers, the UART and the pin synchronisers sit outside this block. The external lines arrive already synchronised and are active low.

Top module: `irqCtrlTop`

## Requirements
- R1: After reset, the enable, priority and external-mode registers are all zero, no level is in service and `irqReq` is low, even when sources are active.
- R2: Enable register (address 0) bit 7 is a global enable. While it is 0, no source can raise `irqReq`.
- R3: Enable register bits 0..4 mask the sources individually, in source-index order: 0 = external line 0, 1 = timer 0, 2 = external line 1, 3 = timer 1, 4 = serial. A masked source raises no request.
- R4: The vector address is 0x0003 + 8 × source index, giving 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R5: When several eligible sources are pending at the same level, the lowest source index wins.
- R6: Priority register (address 1) bit i = 1 places source i at the high level. A pending high-level source wins over any low-level source, whatever their indices.
- R7: While only the low level is in service, a high-level source raises a request and a low-level source does not.
- R8: While the high level is in service, no source raises a request. A `retiIn` pulse clears the high in-service level before the low one.
- R9: The serial source is pending while its receive flag or its transmit flag is set. Acknowledge never clears these flags; only `rxClr` and `txClr` clear them.
- R10: External-mode register (address 2) bit 0 configures line 0 and bit 1 configures line 1; 1 means edge mode. In edge mode, a falling pin edge sets the flag and an acknowledge of that source clears it. In level mode, the flag follows the inverted pin.
- R11: An acknowledge of a timer source clears that timer's flag.
- R12: A source event that is registered at one clock edge raises `irqReq` at the next edge. The request and its vector then hold unchanged until `irqAck`, and `irqReq` falls at the edge that samples the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgAddr | input | 2 | Register select: 0 = enable, 1 = priority, 2 = external mode |
| cfgData | input | 8 | Configuration write data |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| rxDone | input | 1 | Serial receive-complete pulse |
| txDone | input | 1 | Serial transmit-complete pulse |
| rxClr | input | 1 | Clears the serial receive flag |
| txClr | input | 1 | Clears the serial transmit flag |
| ext0N | input | 1 | External line 0, active low |
| ext1N | input | 1 | External line 1, active low |
| irqAck | input | 1 | CPU acknowledge of the current request |
| retiIn | input | 1 | Return-from-interrupt pulse |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVector | output | 16 | Vector address of the current request |

## Verification
A wrong in-service level shows at the ports within one or two cycles. A source either requests when it should be blocked, or stays silent after a `retiIn` that should have released it. For this reason, every preemption and nesting case checks both a request that must appear and a request that must not. A wrong arbitration or a stale flag appears as a wrong vector on the very next request. Serving queued sources one at a time and reading each vector in turn exposes errors in both ordering and flag clearing. Latency faults move the rise of `irqReq` by a cycle, so one scenario samples it on exact cycles.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int SRC_N   = 5;
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;

  typedef logic [SRC_N-1:0] srcVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    take;   // acknowledge accepted this cycle
    srcVec_t sel;    // one-hot source being acknowledged
    logic    high;   // level of the acknowledged source
  } ackStrobe_t;

  typedef enum logic {ST_IDLE, ST_REQ} ctlState_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              tmr0Evt,
  input  logic              tmr1Evt,
  input  logic              rxEvt,
  input  logic              txEvt,
  input  logic              rxClr,
  input  logic              txClr,
  input  logic [1:0]        extPinN,
  input  ackStrobe_t        ackStb,
  input  logic              retiPulse,
  output srcVec_t           eligHigh,
  output srcVec_t           eligLow,
  output logic [1:0]        inService,
  output logic              globalEn
);
  localparam int GEN_BIT = CFG_W - 1;
  localparam logic [CFG_AW-1:0] ADDR_EN   = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] ADDR_PRIO = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] ADDR_MODE = CFG_AW'(2);

  srcVec_t    enMask;
  srcVec_t    prioMask;
  logic [1:0] edgeMode;
  logic       tmr0Flag, tmr1Flag, rxFlag, txFlag;
  logic [1:0] extFlag;
  logic [1:0] extPrevN;
  srcVec_t    pending;
  srcVec_t    elig;
  logic       unusedBits;

  assign unusedBits = ^cfgData[GEN_BIT-1:SRC_N];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      globalEn <= 1'b0;
      prioMask <= '0;
      edgeMode <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == ADDR_EN) begin
        enMask   <= cfgData[SRC_N-1:0];
        globalEn <= cfgData[GEN_BIT];
      end
      if (cfgAddr == ADDR_PRIO) prioMask <= cfgData[SRC_N-1:0];
      if (cfgAddr == ADDR_MODE) edgeMode <= cfgData[1:0];
    end
  end

  // external line flags, one per line
  for (genvar g = 0; g < 2; g++) begin : g_ext
    localparam int IDX = 2 * g;
    logic fallSeen;
    assign fallSeen = extPrevN[g] & ~extPinN[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        extPrevN[g] <= 1'b1;
        extFlag[g]  <= 1'b0;
      end else begin
        extPrevN[g] <= extPinN[g];
        if (edgeMode[g]) begin
          if (fallSeen)                            extFlag[g] <= 1'b1;
          else if (ackStb.take && ackStb.sel[IDX]) extFlag[g] <= 1'b0;
        end else begin
          extFlag[g] <= ~extPinN[g];
        end
      end
    end
  end

  // timer and serial flags; a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr0Flag <= 1'b0;
      tmr1Flag <= 1'b0;
      rxFlag   <= 1'b0;
      txFlag   <= 1'b0;
    end else begin
      tmr0Flag <= tmr0Evt | (tmr0Flag & ~(ackStb.take & ackStb.sel[SRC_TMR0]));
      tmr1Flag <= tmr1Evt | (tmr1Flag & ~(ackStb.take & ackStb.sel[SRC_TMR1]));
      rxFlag   <= rxEvt | (rxFlag & ~rxClr);
      txFlag   <= txEvt | (txFlag & ~txClr);
    end
  end

  always_comb begin
    pending           = '0;
    pending[SRC_EXT0] = extFlag[0];
    pending[SRC_TMR0] = tmr0Flag;
    pending[SRC_EXT1] = extFlag[1];
    pending[SRC_TMR1] = tmr1Flag;
    pending[SRC_SER]  = rxFlag | txFlag;
  end

  assign elig     = pending & enMask & {SRC_N{globalEn}};
  assign eligHigh = elig & prioMask;
  assign eligLow  = elig & ~prioMask;

  // in-service levels: bit 1 high, bit 0 low
  logic [1:0] insSet, insClr;
  always_comb begin
    insSet = '0;
    insClr = '0;
    if (ackStb.take) insSet = ackStb.high ? 2'b10 : 2'b01;
    if (retiPulse)   insClr = inService[1] ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inService <= '0;
    else       inService <= (inService & ~insClr) | insSet;
  end

  // R7: a low-level acknowledge only happens with nothing in service
  p_ack_low_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb.take && !ackStb.high) |-> (inService == 2'b00));
  // R8: a high-level acknowledge never nests inside the high level
  p_ack_high_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb.take && ackStb.high) |-> !inService[1]);
  // R9: acknowledging the serial source leaves it pending
  p_ser_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb.take && ackStb.sel[SRC_SER] && !rxClr && !txClr) |=> pending[SRC_SER]);
  // R11: acknowledging timer 0 drops its flag
  p_tmr_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb.take && ackStb.sel[SRC_TMR0] && !tmr0Evt) |=> !pending[SRC_TMR0]);
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  srcVec_t          eligHigh,
  input  srcVec_t          eligLow,
  input  logic [1:0]       inService,
  input  logic             irqAck,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  output ackStrobe_t       ackStb
);
  ctlState_t state;
  srcVec_t   selReg;
  logic      highReg;
  srcVec_t   candHigh, candLow;
  int        vecIdx;

  function automatic srcVec_t lowestOne(input srcVec_t v);
    return v & srcVec_t'(~v + 1'b1);
  endfunction

  assign candHigh = inService[1]       ? '0 : lowestOne(eligHigh);
  assign candLow  = (inService != 2'b0) ? '0 : lowestOne(eligLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selReg  <= '0;
      highReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (candHigh != '0) begin
            selReg  <= candHigh;
            highReg <= 1'b1;
            state   <= ST_REQ;
          end else if (candLow != '0) begin
            selReg  <= candLow;
            highReg <= 1'b0;
            state   <= ST_REQ;
          end
        end
        ST_REQ: if (irqAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign irqReq = (state == ST_REQ);

  always_comb begin
    vecIdx = 0;
    for (int i = 0; i < SRC_N; i++) if (selReg[i]) vecIdx = i;
  end
  assign irqVector = VEC_W'(VEC_BASE + vecIdx * VEC_STRIDE);

  assign ackStb.take = irqReq & irqAck;
  assign ackStb.sel  = selReg;
  assign ackStb.high = highReg;

  // R12: request and vector hold until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> (irqReq && $stable(irqVector)));
  // R12: request drops after the acknowledge edge
  p_req_drop_r12: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !irqReq);
  // R5: exactly one source is selected while requesting
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($countones(selReg) == 1));
endmodule

// File: rtl/irqCtrlTop.sv
module irqCtrlTop
  import irqPkg::*;
#(
  parameter int CFG_W      = 8,
  parameter int CFG_AW     = 2,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              tmr0Ovf,
  input  logic              tmr1Ovf,
  input  logic              rxDone,
  input  logic              txDone,
  input  logic              rxClr,
  input  logic              txClr,
  input  logic              ext0N,
  input  logic              ext1N,
  input  logic              irqAck,
  input  logic              retiIn,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector
);
  srcVec_t    eligHigh, eligLow;
  logic [1:0] inService;
  logic       globalEn;
  ackStrobe_t ackStb;

  irqDatapath #(.CFG_W(CFG_W), .CFG_AW(CFG_AW)) datapath_i (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tmr0Evt(tmr0Ovf), .tmr1Evt(tmr1Ovf), .rxEvt(rxDone), .txEvt(txDone),
    .rxClr(rxClr), .txClr(txClr), .extPinN({ext1N, ext0N}),
    .ackStb(ackStb), .retiPulse(retiIn),
    .eligHigh(eligHigh), .eligLow(eligLow),
    .inService(inService), .globalEn(globalEn)
  );

  irqControl #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) control_i (
    .clk(clk), .rstN(rstN),
    .eligHigh(eligHigh), .eligLow(eligLow), .inService(inService),
    .irqAck(irqAck), .irqReq(irqReq), .irqVector(irqVector), .ackStb(ackStb)
  );

  // R2: a new request only follows a cycle with the global enable set
  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(globalEn));
endmodule

// File: tb/irqCtrlTop_tb.sv
module irqCtrlTop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        tmr0Ovf = 1'b0, tmr1Ovf = 1'b0, rxDone = 1'b0, txDone = 1'b0;
  logic        rxClr = 1'b0, txClr = 1'b0;
  logic        ext0N = 1'b1, ext1N = 1'b1;
  logic        irqAck = 1'b0, retiIn = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irqCtrlTop dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .tmr0Ovf(tmr0Ovf), .tmr1Ovf(tmr1Ovf), .rxDone(rxDone), .txDone(txDone),
    .rxClr(rxClr), .txClr(txClr), .ext0N(ext0N), .ext1N(ext1N),
    .irqAck(irqAck), .retiIn(retiIn), .irqReq(irqReq), .irqVector(irqVector)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWe = 1'b0; tmr0Ovf = 0; tmr1Ovf = 0; rxDone = 0; txDone = 0;
    rxClr = 0; txClr = 0; ext0N = 1; ext1N = 1; irqAck = 0; retiIn = 0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic writeCfg(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    tick(1);
    cfgWe = 1'b0;
  endtask

  task automatic fire(input bit ft0, input bit ft1, input bit frx, input bit ftx);
    tmr0Ovf = ft0; tmr1Ovf = ft1; rxDone = frx; txDone = ftx;
    tick(1);
    tmr0Ovf = 0; tmr1Ovf = 0; rxDone = 0; txDone = 0;
  endtask

  task automatic ack();
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
  endtask

  task automatic reti();
    retiIn = 1'b1; tick(1); retiIn = 1'b0;
  endtask

  // acknowledge, return, and give the arbiter one edge
  task automatic serve();
    ack(); reti(); tick(1);
  endtask

  task automatic expectReq(input string tag, input logic [15:0] expVec);
    total++;
    if (!irqReq || irqVector !== expVec) begin
      bad++;
      $display("FAIL %s: req=%0b vec=%h expected req=1 vec=%h", tag, irqReq, irqVector, expVec);
    end
  endtask

  task automatic expectIdle(input string tag);
    total++;
    if (irqReq !== 1'b0) begin
      bad++;
      $display("FAIL %s: req=%0b vec=%h expected req=0", tag, irqReq, irqVector);
    end
  endtask

  task automatic testResetR1();
    doReset();
    expectIdle("R1 after reset");
    ext0N = 0;
    fire(1, 1, 1, 1);
    tick(3);
    expectIdle("R1 defaults mask all sources");
  endtask

  task automatic testGlobalR2();
    doReset();
    writeCfg(0, 8'h1F);
    fire(1, 0, 0, 0);
    tick(2);
    expectIdle("R2 global enable clear");
    writeCfg(0, 8'h9F);
    tick(1);
    expectReq("R2 global enable set", 16'h000B);
  endtask

  task automatic testMaskR3();
    doReset();
    writeCfg(0, 8'h81);
    fire(1, 0, 0, 0);
    tick(2);
    expectIdle("R3 timer0 masked");
    writeCfg(0, 8'h83);
    tick(1);
    expectReq("R3 timer0 unmasked", 16'h000B);
  endtask

  task automatic testOrderR5();
    doReset();
    writeCfg(0, 8'h9F);
    writeCfg(2, 8'h03);
    ext0N = 0; ext1N = 0;
    fire(1, 1, 1, 0);
    tick(1);
    expectReq("R5 R4 first INT0 0003", 16'h0003);
    serve();
    expectReq("R5 R4 second timer0 000B", 16'h000B);
    serve();
    expectReq("R5 R4 third INT1 0013", 16'h0013);
    serve();
    expectReq("R5 R4 fourth timer1 001B", 16'h001B);
    serve();
    expectReq("R5 R4 fifth serial 0023", 16'h0023);
  endtask

  task automatic testPrioR6();
    doReset();
    writeCfg(0, 8'h9F);
    writeCfg(1, 8'h10);
    fire(1, 0, 1, 0);
    tick(1);
    expectReq("R6 high serial beats low timer0", 16'h0023);
  endtask

  task automatic testPreemptR7R8();
    doReset();
    writeCfg(0, 8'h9F);
    writeCfg(1, 8'h04);
    writeCfg(2, 8'h02);
    fire(1, 0, 0, 0);
    tick(1);
    expectReq("R7 low timer0 granted", 16'h000B);
    ack();
    fire(0, 1, 0, 0);
    tick(3);
    expectIdle("R7 low waits behind low");
    ext1N = 0;
    tick(2);
    expectReq("R7 high INT1 preempts", 16'h0013);
    ack();
    ext1N = 1;
    reti();
    tick(2);
    expectIdle("R8 first return clears high only");
    reti();
    tick(1);
    expectReq("R8 second return frees low", 16'h001B);
  endtask

  task automatic testHighBlocksR8();
    doReset();
    writeCfg(0, 8'h9F);
    writeCfg(1, 8'h1F);
    fire(1, 0, 0, 0);
    tick(1);
    expectReq("R8 high timer0", 16'h000B);
    ack();
    fire(0, 1, 0, 0);
    tick(3);
    expectIdle("R8 high blocks high");
    reti();
    tick(1);
    expectReq("R8 released after return", 16'h001B);
  endtask

  task automatic testSerialR9();
    doReset();
    writeCfg(0, 8'h90);
    fire(0, 0, 0, 1);
    tick(1);
    expectReq("R9 transmit flag requests", 16'h0023);
    serve();
    expectReq("R9 ack does not clear serial", 16'h0023);
    ack();
    txClr = 1; tick(1); txClr = 0;
    reti();
    tick(2);
    expectIdle("R9 cleared by txClr");
    fire(0, 0, 1, 0);
    tick(1);
    expectReq("R9 receive flag requests", 16'h0023);
  endtask

  task automatic testExtModesR10();
    doReset();
    writeCfg(0, 8'h81);
    ext0N = 0;
    tick(2);
    expectReq("R10 level mode low pin", 16'h0003);
    serve();
    expectReq("R10 level mode re-requests", 16'h0003);
    ext0N = 1;
    tick(1);
    ack(); reti();
    tick(2);
    expectIdle("R10 level released pin");
    writeCfg(2, 8'h01);
    ext0N = 0;
    tick(2);
    expectReq("R10 edge mode falling edge", 16'h0003);
    serve();
    tick(1);
    expectIdle("R10 edge flag cleared by ack");
  endtask

  task automatic testTimerClearR11();
    doReset();
    writeCfg(0, 8'h88);
    fire(0, 1, 0, 0);
    tick(1);
    expectReq("R11 timer1 requests", 16'h001B);
    serve();
    tick(1);
    expectIdle("R11 timer1 flag cleared by ack");
  endtask

  task automatic testTimingR12();
    doReset();
    writeCfg(0, 8'h82);
    fire(1, 0, 0, 0);
    expectIdle("R12 not yet after flag edge");
    tick(1);
    expectReq("R12 request one edge later", 16'h000B);
    tick(3);
    expectReq("R12 request held", 16'h000B);
    ack();
    expectIdle("R12 drops after ack");
  endtask

  initial begin
    testResetR1();
    testGlobalR2();
    testMaskR3();
    testOrderR5();
    testPrioR6();
    testPreemptR7R8();
    testHighBlocksR8();
    testSerialR9();
    testExtModesR10();
    testTimerClearR11();
    testTimingR12();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule